// File: doc/BRIEF.md
# HDLC Receive Frame FIFO

This block buffers received HDLC frame bytes between a serial deframer and a host processor. The deframer hands over one byte per write strobe, with flags that mark the first and the last byte of a frame. The bytes are stored in 64 bytes of storage, organised as eight 8-byte blocks. Blocks are claimed in ring order as bytes arrive, and every frame starts on a fresh block. This means several short frames can sit in the buffer together.

The host never sees the whole buffer. It sees one *portion* at a time. A portion is either a complete frame shorter than the hand-over size, or one 32-byte slice of a longer frame, or the tail of such a frame. While a portion is presented, the interrupt line is high, a count output gives the portion's byte count, and two flags say whether the portion closes its frame and whether the frame was cut short. The host reads the portion through a 32-byte offset window and then pulses a release input. The release returns the portion's blocks to the ring and brings up the next queued portion on the following cycle.

If a byte needs a new block and all blocks are held, a sticky overflow flag is raised. The rest of that frame is thrown away, and any part of it that was already stored is marked aborted.

Top module: `hrf_rx_fifo`

## Requirements
- R1: After reset, irq, overflow, rd_count, rd_last and rd_abort are all 0.
- R2: A frame that ends within its first 32 bytes is presented as one portion. That portion has rd_count equal to the frame length, rd_last=1 and rd_abort=0. It appears on the cycle after the clock edge that took its last byte.
- R3: While a portion is presented, rd_data shows, one clock after rd_addr is sampled, the byte at that offset of the portion. Offset 0 is the portion's first received byte.
- R4: Each time 32 bytes of a frame have been stored without an end marker, a portion with rd_count=32 and rd_last=0 is queued. The remaining bytes of the frame follow as further portions, and the last one has rd_last=1. A frame whose end falls exactly on a 32-byte boundary ends with a 32-byte portion that has rd_last=1.
- R5: Portions are presented one at a time, in arrival order. irq is high exactly while a portion is presented. A release pulse sampled while irq=1 presents the next queued portion, or drops irq, on the next cycle.
- R6: A 64-byte frame fits completely into an empty buffer and yields two 32-byte portions without overflow.
- R7: A portion holds ceil(rd_count/8) blocks. A byte that starts a block is accepted only if fewer than 8 blocks are held at the start of its cycle. A release in the same cycle does not make room for that byte.
- R8: A byte refused for lack of a block sets overflow, which stays 1 until reset. If part of that frame is already queued, a closing portion with rd_abort=1 and rd_last=1 is queued. Its rd_count is the number of bytes stored since the previous portion boundary, which may be 0. Later bytes of that frame are discarded.
- R9: If the first byte of a frame is refused, no portion is queued for that frame. Up to eight one-block frames are held and presented in order.
- R10: A byte without the start flag is ignored while no frame is open. A start flag on a byte inside an open frame is treated as ordinary data.
- R11: A release pulse while irq=0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte strobe from the deframer |
| wr_data | input | 8 | Received byte |
| wr_sof | input | 1 | Byte is the first byte of a frame |
| wr_eof | input | 1 | Byte is the last byte of a frame |
| rd_addr | input | 5 | Byte offset inside the presented portion |
| rel | input | 1 | Host release of the presented portion |
| rd_data | output | 8 | Byte at the offset sampled on the previous clock |
| irq | output | 1 | A portion is presented |
| rd_count | output | 6 | Byte count of the presented portion |
| rd_last | output | 1 | Presented portion closes its frame |
| rd_abort | output | 1 | Presented portion belongs to a frame cut short by overflow |
| overflow | output | 1 | Sticky: a byte was refused for lack of a block |

## Verification
The risky coincidence is a release and a block-claiming byte arriving in the same cycle while all eight blocks are held. The bench fills the ring with a 64-byte frame. It then drives a start-of-frame byte together with a release pulse. It requires overflow to rise, and it requires the refused frame to leave no portion, even though four blocks come free at that edge. A queue push and a queue pop also land in the same cycle during streaming reads. The behavioural reference model is compared on every clock, so any lost or duplicated portion in that case shows up at once.

// File: rtl/hrf_pkg.sv
package hrf_pkg;

  // Write-side frame state
  typedef enum logic [1:0] {
    WS_IDLE = 2'd0,  // no frame open
    WS_OPEN = 2'd1,  // frame in progress, bytes stored
    WS_DROP = 2'd2   // frame hit overflow, discarding to end marker
  } hrf_wstate_e;

endpackage

// File: rtl/hrf_byte_ram.sv
module hrf_byte_ram #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // simple dual port, registered read: maps onto block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/hrf_blk_pool.sv
module hrf_blk_pool #(
  parameter int NUM_BLKS = 8,
  localparam int UCW = $clog2(NUM_BLKS + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           alloc,
  input  logic [UCW-1:0] free_n,
  output logic           room
);
  logic [UCW-1:0] used;

  assign room = (used < UCW'(NUM_BLKS));

  always_ff @(posedge clk) begin
    if (rst) used <= '0;
    else     used <= used + UCW'(alloc) - free_n;
  end

  AST_POOL_BOUND: assert property (@(posedge clk) disable iff (rst)
    used <= UCW'(NUM_BLKS)); // R7
  AST_POOL_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    free_n <= used); // R7
  AST_POOL_CLAIM_ROOM: assert property (@(posedge clk) disable iff (rst)
    alloc |-> room); // R7
endmodule

// File: rtl/hrf_desc_queue.sv
module hrf_desc_queue #(
  parameter int DW    = 11,
  parameter int DEPTH = 16,
  localparam int PW = $clog2(DEPTH),
  localparam int NW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic          valid,
  output logic          full
);
  logic [DW-1:0] slots [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [NW-1:0] cnt;
  logic          pop_ok;

  assign valid  = (cnt != '0);
  assign full   = (cnt == NW'(DEPTH));
  assign pop_ok = pop && valid;
  assign head   = slots[rp];

  always_ff @(posedge clk) begin
    if (push) slots[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push)   wp <= wp + PW'(1);
      if (pop_ok) rp <= rp + PW'(1);
      cnt <= cnt + NW'(push) - NW'(pop_ok);
    end
  end

  AST_DQ_NO_OVERRUN: assert property (@(posedge clk) disable iff (rst)
    push |-> !full); // R5
  AST_DQ_POP_ADVANCES: assert property (@(posedge clk) disable iff (rst)
    (pop && valid && !push) |=> (cnt == $past(cnt) - NW'(1))); // R5
endmodule

// File: rtl/hrf_wr_ctrl.sv
module hrf_wr_ctrl
  import hrf_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int BLK_BYTES   = 8,
  parameter int NUM_BLKS    = 8,
  parameter int CHUNK_BYTES = 32,
  localparam int BW = $clog2(NUM_BLKS),
  localparam int OW = $clog2(BLK_BYTES),
  localparam int AW = BW + OW,
  localparam int CW = $clog2(CHUNK_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_sof,
  input  logic              wr_eof,
  input  logic              room,
  output logic              alloc,
  output logic              mem_we,
  output logic [AW-1:0]     mem_waddr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              dq_push,
  output logic [BW-1:0]     dq_start,
  output logic [CW-1:0]     dq_len,
  output logic              dq_last,
  output logic              dq_abort,
  output logic              ovf
);
  hrf_wstate_e   state;
  logic [CW-1:0] plen;      // bytes in the open portion
  logic [BW-1:0] pstart;    // first block of the open portion
  logic [BW-1:0] nxt_blk;   // next block to claim (ring order)

  logic          starting, active, need_blk, blocked, accept;
  logic [CW-1:0] len_base, len_inc;
  logic [BW-1:0] seg_start;

  always_comb begin
    starting  = wr_en && wr_sof && (state != WS_OPEN);
    active    = wr_en && (starting || (state == WS_OPEN));
    len_base  = starting ? '0 : plen;
    need_blk  = (len_base[OW-1:0] == '0);
    blocked   = active && need_blk && !room;
    accept    = active && !blocked;
    len_inc   = len_base + CW'(1);
    seg_start = (len_base == '0) ? nxt_blk : pstart;
  end

  assign alloc     = accept && need_blk;
  assign mem_we    = accept;
  assign mem_wdata = wr_data;
  assign mem_waddr = {seg_start, {OW{1'b0}}} + AW'(len_base);

  assign dq_push  = (blocked && (state == WS_OPEN)) ||
                    (accept && (wr_eof || (len_inc == CW'(CHUNK_BYTES))));
  assign dq_start = seg_start;
  assign dq_len   = blocked ? plen : len_inc;
  assign dq_last  = blocked || wr_eof;
  assign dq_abort = blocked;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= WS_IDLE;
      plen    <= '0;
      pstart  <= '0;
      nxt_blk <= '0;
      ovf     <= 1'b0;
    end else begin
      if (alloc) nxt_blk <= nxt_blk + BW'(1);
      if (accept && (len_base == '0)) pstart <= nxt_blk;
      if (blocked) begin
        ovf   <= 1'b1;
        plen  <= '0;
        state <= wr_eof ? WS_IDLE : WS_DROP;
      end else if (accept) begin
        state <= wr_eof ? WS_IDLE : WS_OPEN;
        if (wr_eof || (len_inc == CW'(CHUNK_BYTES))) plen <= '0;
        else                                          plen <= len_inc;
      end else if (wr_en && (state == WS_DROP) && wr_eof) begin
        state <= WS_IDLE;
      end
    end
  end

  AST_WR_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    ovf |=> ovf); // R8
  AST_WR_DROP_SILENT: assert property (@(posedge clk) disable iff (rst)
    ((state == WS_DROP) && !(wr_en && wr_sof)) |-> !mem_we); // R8
  AST_WR_IDLE_SILENT: assert property (@(posedge clk) disable iff (rst)
    ((state == WS_IDLE) && !wr_sof) |-> !mem_we); // R10
  AST_WR_LEN_RANGE: assert property (@(posedge clk) disable iff (rst)
    plen < CW'(CHUNK_BYTES)); // R4
endmodule

// File: rtl/hrf_rx_fifo.sv
module hrf_rx_fifo #(
  parameter int DATA_W      = 8,
  parameter int BLK_BYTES   = 8,
  parameter int NUM_BLKS    = 8,
  parameter int CHUNK_BYTES = 32,
  localparam int BW  = $clog2(NUM_BLKS),
  localparam int OW  = $clog2(BLK_BYTES),
  localparam int AW  = BW + OW,
  localparam int CW  = $clog2(CHUNK_BYTES + 1),
  localparam int RAW = $clog2(CHUNK_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_sof,
  input  logic              wr_eof,
  input  logic [RAW-1:0]    rd_addr,
  input  logic              rel,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq,
  output logic [CW-1:0]     rd_count,
  output logic              rd_last,
  output logic              rd_abort,
  output logic              overflow
);
  localparam int UCW   = $clog2(NUM_BLKS + 1);
  localparam int DQW   = BW + CW + 2;
  localparam int DQD   = 2 * NUM_BLKS;
  localparam int RW    = CW + 1;

  logic              room, alloc, mem_we;
  logic [AW-1:0]     mem_waddr, mem_raddr;
  logic [DATA_W-1:0] mem_wdata;
  logic              dq_push, dq_last, dq_abort, dq_valid, dq_full;
  logic [BW-1:0]     dq_start, h_start;
  logic [CW-1:0]     dq_len, h_len;
  logic              h_last, h_abort, pop_ok;
  logic [DQW-1:0]    dq_in, dq_head;
  logic [RW-1:0]     rounded;
  logic [UCW-1:0]    free_n;

  hrf_wr_ctrl #(
    .DATA_W(DATA_W), .BLK_BYTES(BLK_BYTES),
    .NUM_BLKS(NUM_BLKS), .CHUNK_BYTES(CHUNK_BYTES)
  ) u_wr (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .wr_sof(wr_sof), .wr_eof(wr_eof), .room(room), .alloc(alloc),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .dq_push(dq_push), .dq_start(dq_start), .dq_len(dq_len),
    .dq_last(dq_last), .dq_abort(dq_abort), .ovf(overflow)
  );

  hrf_byte_ram #(.DATA_W(DATA_W), .ADDR_W(AW)) u_ram (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(mem_raddr), .rdata(rd_data)
  );

  assign dq_in = {dq_start, dq_len, dq_last, dq_abort};
  assign {h_start, h_len, h_last, h_abort} = dq_head;

  hrf_desc_queue #(.DW(DQW), .DEPTH(DQD)) u_dq (
    .clk(clk), .rst(rst), .push(dq_push), .din(dq_in), .pop(rel),
    .head(dq_head), .valid(dq_valid), .full(dq_full)
  );

  // blocks returned by a release: ceil(count / block size)
  assign pop_ok  = rel && dq_valid;
  assign rounded = RW'(h_len) + RW'(BLK_BYTES - 1);
  assign free_n  = pop_ok ? UCW'(rounded >> OW) : '0;

  hrf_blk_pool #(.NUM_BLKS(NUM_BLKS)) u_pool (
    .clk(clk), .rst(rst), .alloc(alloc), .free_n(free_n), .room(room)
  );

  assign mem_raddr = {h_start, {OW{1'b0}}} + AW'(rd_addr);

  assign irq      = dq_valid;
  assign rd_count = dq_valid ? h_len : '0;
  assign rd_last  = dq_valid && h_last;
  assign rd_abort = dq_valid && h_abort;

  AST_TOP_COUNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    irq |-> (rd_count <= CW'(CHUNK_BYTES))); // R4
  AST_TOP_MID_FULL: assert property (@(posedge clk) disable iff (rst)
    (irq && !rd_last) |-> (rd_count == CW'(CHUNK_BYTES))); // R4
  AST_TOP_ABORT_CLOSES: assert property (@(posedge clk) disable iff (rst)
    rd_abort |-> rd_last); // R8
  AST_TOP_CLEAN_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
    (irq && !rd_abort) |-> (rd_count != '0)); // R2
  AST_TOP_NO_FULL_QUEUE: assert property (@(posedge clk) disable iff (rst)
    !dq_full); // R5
endmodule

// File: tb/test_hrf_rx_fifo.sv
`timescale 1ns/1ps
module test_hrf_rx_fifo;
  localparam int CH = 32;
  localparam int NB = 8;
  localparam int BB = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, wr_sof = 1'b0, wr_eof = 1'b0, rel = 1'b0;
  logic [7:0] wr_data = '0;
  logic [4:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic [5:0] rd_count;
  logic       irq, rd_last, rd_abort, overflow;

  int checks = 0, failures = 0, cyc = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  hrf_rx_fifo i_hrf_rx_fifo (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .wr_sof(wr_sof), .wr_eof(wr_eof), .rd_addr(rd_addr), .rel(rel),
    .rd_data(rd_data), .irq(irq), .rd_count(rd_count), .rd_last(rd_last),
    .rd_abort(rd_abort), .overflow(overflow)
  );

  // ---------------- behavioural reference model ----------------
  int           m_used = 0, m_state = 0, m_plen = 0, m_add, m_fr;
  bit           m_ovf = 0, m_start, m_need, m_open;
  logic [255:0] m_cur = '0, m_tmp;
  int           q_len[$];
  bit           q_last[$], q_abort[$];
  logic [255:0] q_dat[$];
  logic [7:0]   e_data = '0;
  bit           e_dv = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_used = 0; m_state = 0; m_plen = 0; m_ovf = 0; e_dv = 0;
      q_len.delete(); q_last.delete(); q_abort.delete(); q_dat.delete();
    end else begin
      m_add = 0; m_fr = 0; e_dv = 0;
      if (q_len.size() > 0 && int'(rd_addr) < q_len[0]) begin
        m_tmp = q_dat[0]; e_data = m_tmp[int'(rd_addr)*8 +: 8]; e_dv = 1;
      end
      if (rel && q_len.size() > 0) begin
        m_fr = (q_len[0] + BB - 1) / BB;
        void'(q_len.pop_front()); void'(q_last.pop_front());
        void'(q_abort.pop_front()); void'(q_dat.pop_front());
      end
      if (wr_en) begin
        m_open  = (m_state == 1);
        m_start = wr_sof && !m_open;
        if (m_start || m_open) begin
          if (m_start) m_plen = 0;
          m_need = (m_plen % BB) == 0;
          if (m_need && m_used == NB) begin
            m_ovf = 1;
            if (m_open) begin
              q_len.push_back(m_plen); q_last.push_back(1);
              q_abort.push_back(1); q_dat.push_back(m_cur);
            end
            m_plen = 0; m_state = wr_eof ? 0 : 2;
          end else begin
            if (m_need) m_add = 1;
            m_cur[m_plen*8 +: 8] = wr_data;
            m_plen++;
            if (wr_eof) begin
              q_len.push_back(m_plen); q_last.push_back(1);
              q_abort.push_back(0); q_dat.push_back(m_cur);
              m_plen = 0; m_state = 0;
            end else if (m_plen == CH) begin
              q_len.push_back(CH); q_last.push_back(0);
              q_abort.push_back(0); q_dat.push_back(m_cur);
              m_plen = 0; m_state = 1;
            end else m_state = 1;
          end
        end else if (m_state == 2 && wr_eof) m_state = 0;
      end
      m_used = m_used + m_add - m_fr;
    end
  end

  task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (!done && !rst) begin
      cmp("R5 irq", 32'(irq), 32'(q_len.size() > 0));
      cmp("R4 rd_count", 32'(rd_count), (q_len.size() > 0) ? 32'(q_len[0]) : 32'd0);
      cmp("R2 rd_last", 32'(rd_last), (q_len.size() > 0) ? 32'(q_last[0]) : 32'd0);
      cmp("R8 rd_abort", 32'(rd_abort), (q_len.size() > 0) ? 32'(q_abort[0]) : 32'd0);
      cmp("R8 overflow", 32'(overflow), 32'(m_ovf));
      if (e_dv) cmp("R3 rd_data", 32'(rd_data), 32'(e_data));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic drive(bit we, logic [7:0] d, bit s, bit e, bit r, logic [4:0] a);
    @(negedge clk);
    wr_en = we; wr_data = d; wr_sof = s; wr_eof = e; rel = r; rd_addr = a;
  endtask

  task automatic idle();
    drive(0, 8'h00, 0, 0, 0, 5'd0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; wr_en = 0; wr_sof = 0; wr_eof = 0; rel = 0; rd_addr = '0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic send(logic [7:0] base, int first, int cnt, int total);
    for (int i = first; i < first + cnt; i++)
      drive(1, base + 8'(i), i == 0, i == total - 1, 0, 5'd0);
  endtask

  task automatic take();
    int n;
    n = (q_len.size() > 0) ? q_len[0] : 0;
    for (int i = 0; i < n; i++) drive(0, 8'h00, 0, 0, 0, 5'(i));
    drive(0, 8'h00, 0, 0, 1, 5'd0);
    idle();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    cmp("R1 irq", 32'(irq), 0);
    cmp("R1 overflow", 32'(overflow), 0);
    cmp("R1 rd_count", 32'(rd_count), 0);
    cmp("R1 rd_last", 32'(rd_last), 0);

    // R2 short frame, R3 data window
    send(8'h10, 0, 5, 5); idle();
    cmp("R2 count", 32'(rd_count), 5);
    cmp("R2 last", 32'(rd_last), 1);
    drive(0, 8'h00, 0, 0, 0, 5'd2); idle();
    cmp("R3 offset2", 32'(rd_data), 32'h12);
    take();
    cmp("R5 irq after release", 32'(irq), 0);

    // R4 long frame of 70 bytes, host drains midway
    send(8'h40, 0, 40, 70); idle();
    cmp("R4 first piece count", 32'(rd_count), 32);
    cmp("R4 first piece last", 32'(rd_last), 0);
    take();
    send(8'h40, 40, 30, 70); idle();
    cmp("R4 second piece count", 32'(rd_count), 32);
    take();
    cmp("R4 tail count", 32'(rd_count), 6);
    cmp("R4 tail last", 32'(rd_last), 1);
    take();

    // R6 64-byte frame fits whole
    send(8'h80, 0, 64, 64); idle();
    cmp("R6 overflow", 32'(overflow), 0);
    cmp("R6 first count", 32'(rd_count), 32);
    take();
    cmp("R6 second count", 32'(rd_count), 32);
    cmp("R6 second last", 32'(rd_last), 1);
    take();

    // R10 stray byte ignored, inner start flag is data
    drive(1, 8'hEE, 0, 0, 0, 5'd0);
    for (int i = 0; i < 6; i++) drive(1, 8'hA0 + 8'(i), i == 0 || i == 3, i == 5, 0, 5'd0);
    idle();
    cmp("R10 count", 32'(rd_count), 6);
    drive(0, 8'h00, 0, 0, 0, 5'd0); idle();
    cmp("R10 first byte", 32'(rd_data), 32'hA0);
    take();

    // R11 release with nothing presented
    drive(0, 8'h00, 0, 0, 1, 5'd0); idle();
    cmp("R11 irq", 32'(irq), 0);
    send(8'h30, 0, 2, 2); idle();
    cmp("R11 next count", 32'(rd_count), 2);
    take();

    // R8 overflow in mid frame: A=40 bytes (5 blocks), B=30 bytes
    send(8'h01, 0, 40, 40);
    send(8'h60, 0, 30, 30); idle();
    cmp("R8 flag", 32'(overflow), 1);
    take(); take();
    cmp("R8 abort count", 32'(rd_count), 24);
    cmp("R8 abort flag", 32'(rd_abort), 1);
    cmp("R8 abort last", 32'(rd_last), 1);
    take();
    // R8 zero-length abort: D=30 bytes, E overflows right after a 32-byte piece
    send(8'h05, 0, 30, 30);
    send(8'h90, 0, 40, 40); idle();
    take(); take();
    cmp("R8 zero count", 32'(rd_count), 0);
    cmp("R8 zero abort", 32'(rd_abort), 1);
    cmp("R8 zero irq", 32'(irq), 1);
    take();
    cmp("R8 sticky", 32'(overflow), 1);

    // R9 eight short frames, ninth refused at its first byte
    do_reset();
    for (int f = 0; f < 8; f++) send(8'(f * 16), 0, 3, 3);
    send(8'hF0, 0, 3, 3); idle();
    cmp("R9 overflow", 32'(overflow), 1);
    for (int f = 0; f < 8; f++) begin
      drive(0, 8'h00, 0, 0, 0, 5'd0); idle();
      cmp("R5 order first byte", 32'(rd_data), 32'(f * 16));
      cmp("R9 count", 32'(rd_count), 3);
      take();
    end
    cmp("R9 no portion for refused frame", 32'(irq), 0);

    // R7 release and block claim in the same cycle while full
    do_reset();
    send(8'hC0, 0, 64, 64); idle();
    cmp("R7 no overflow yet", 32'(overflow), 0);
    drive(1, 8'h77, 1, 1, 1, 5'd0); idle();
    cmp("R7 overflow despite release", 32'(overflow), 1);
    cmp("R7 remaining count", 32'(rd_count), 32);
    cmp("R7 remaining last", 32'(rd_last), 1);
    send(8'h55, 0, 1, 1); idle();
    take();
    cmp("R7 later byte accepted", 32'(rd_count), 1);
    take();
    idle();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule